// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

The block sits between two eight-bit ports, A and B, and keeps one bank of storage for each direction of flow. Every direction has three active-low controls of its own: a chip enable, a latch enable and an output enable. The chip enable has to be low before that direction does anything. While the chip enable and the latch enable are both low, the bank is open. The destination port then follows the source port in the same combinational evaluation. When the latch enable goes high, the bank holds what it took in. While the chip enable and the output enable are both low, the stored or passed-through value drives the destination port without inversion.

The ports are not true tri-state pins. Each one is split into an input bus, an output bus and an output-enable flag, so a wrapper can add the pad buffers and a bench can watch for contention. The storage runs on the system clock. While a bank is open it takes in its source port on every rising clock edge. When the bank is open, its output bypasses that register, so the pass-through has no clock delay. Once the bank closes, the output comes from the register.

Top module: `bus_xcvr`

## Requirements
- R1: While rst_n is low, both output-enable flags are 0 and both output buses are 0. After reset, both banks hold zero.
- R2: While a direction's chip enable and latch enable are both low, its destination output bus equals its source input bus in the same evaluation, with no clock delay.
- R3: While a direction's latch enable is high, changes on its source input bus do not change the value that direction drives.
- R4: While a direction's chip enable is high, its bank keeps its value whatever its latch enable and source bus do. The value is shown once the chip enable is low again with the latch enable high.
- R5: A direction's output-enable flag is 1 exactly when its chip enable and output enable are both low and rst_n is high. While the flag is 0, that output bus reads 0.
- R6: The B-to-A direction (ba_* controls, source b_in, destination a_out/a_oe) behaves like the A-to-B direction (ab_* controls, source a_in, destination b_out/b_oe). Operating one direction never changes what the other drives.
- R7: The driven value is not inverted: each output bit equals the same bit of the stored or passed value.
- R8: The value a bank holds after closing is the source bus value at the last rising clock edge at which the bank was open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Storage clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 8 | Value seen on port A |
| a_out | output | 8 | Value driven onto port A (0 when not driving) |
| a_oe | output | 1 | Port A driver enable |
| b_in | input | 8 | Value seen on port B |
| b_out | output | 8 | Value driven onto port B (0 when not driving) |
| b_oe | output | 1 | Port B driver enable |
| ab_ce_n | input | 1 | A-to-B chip enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low (low = open) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_ce_n | input | 1 | B-to-A chip enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low (low = open) |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
Pass-through and driver-enable results are due with zero cycles of latency. The bench drives each input on a falling clock edge and samples one nanosecond later, before the next rising edge. A stored value becomes visible one rising edge after the bank was last open. The bench therefore leaves the source bus stable across at least one rising edge before it raises the latch enable. Only after that does it move the source, so hold results are compared with the value that was present at that edge. Every expected value comes from the enable rules restated in the bench, run through exhaustive sweeps of data values and enable combinations.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
  localparam int unsigned XW = 8;
  typedef logic [XW-1:0] xdata_t;

  // bank accepts its source while both enables are low
  function automatic logic bank_open(input logic ce_n, input logic le_n);
    return ~ce_n & ~le_n;
  endfunction

  // destination drivers are on while both enables are low
  function automatic logic drive_on(input logic ce_n, input logic oe_n);
    return ~ce_n & ~oe_n;
  endfunction
endpackage

// File: rtl/latch_bank.sv
module latch_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_n,
  input  logic         le_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] view
);
  import bus_xcvr_pkg::*;

  logic         open_now;
  logic [W-1:0] held_q;

  assign open_now = bank_open(ce_n, le_n) & rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        held_q <= '0;
    else if (open_now) held_q <= src;
  end

  assign view = open_now ? src : held_q;

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(open_now) |-> $stable(held_q));
  // R8
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(open_now) |-> held_q == $past(src));
  // R2
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !le_n) |-> view == src);
endmodule

// File: rtl/drive_gate.sv
module drive_gate #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_n,
  input  logic         oe_n,
  input  logic [W-1:0] data,
  output logic [W-1:0] out,
  output logic         oe
);
  import bus_xcvr_pkg::*;

  assign oe  = drive_on(ce_n, oe_n) & rst_n;
  assign out = oe ? data : '0;

  // R5
  drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (!oe && out == '0));
  // R7
  drive_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> out == data);
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int unsigned W = bus_xcvr_pkg::XW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  input  logic         ab_ce_n,
  input  logic         ab_le_n,
  input  logic         ab_oe_n,
  input  logic         ba_ce_n,
  input  logic         ba_le_n,
  input  logic         ba_oe_n
);
  localparam int unsigned NDIR = 2;

  logic [W-1:0] src_v  [NDIR];
  logic [W-1:0] view_v [NDIR];
  logic [W-1:0] out_v  [NDIR];
  logic         oe_v   [NDIR];
  logic         ce_v   [NDIR];
  logic         le_v   [NDIR];
  logic         oen_v  [NDIR];

  // index 0: A to B, index 1: B to A
  assign src_v[0] = a_in;    assign src_v[1] = b_in;
  assign ce_v[0]  = ab_ce_n; assign ce_v[1]  = ba_ce_n;
  assign le_v[0]  = ab_le_n; assign le_v[1]  = ba_le_n;
  assign oen_v[0] = ab_oe_n; assign oen_v[1] = ba_oe_n;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    latch_bank #(.W(W)) i_bank (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_v[d]), .le_n(le_v[d]),
      .src(src_v[d]), .view(view_v[d])
    );
    drive_gate #(.W(W)) i_gate (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_v[d]), .oe_n(oen_v[d]),
      .data(view_v[d]), .out(out_v[d]), .oe(oe_v[d])
    );
  end

  assign b_out = out_v[0];
  assign b_oe  = oe_v[0];
  assign a_out = out_v[1];
  assign a_oe  = oe_v[1];

  // R6
  ab_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_ce_n && $past(ab_ce_n)) |-> ($stable(b_out) && !b_oe));
  // R1
  rst_off_chk: assert property (@(posedge clk) !rst_n |-> (!a_oe && !b_oe));
endmodule

// File: tb/test_bus_xcvr.sv
module test_bus_xcvr;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic [W-1:0] a_in = 0, b_in = 0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe;
  logic ab_ce_n = 1, ab_le_n = 1, ab_oe_n = 1;
  logic ba_ce_n = 1, ba_le_n = 1, ba_oe_n = 1;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bus_xcvr #(.W(W)) i_bus_xcvr (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_ce_n(ab_ce_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_ce_n(ba_ce_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    // R1 during reset
    ab_ce_n = 0; ab_oe_n = 0; ba_ce_n = 0; ba_oe_n = 0; a_in = 8'h5a; b_in = 8'ha5;
    repeat (3) step();
    #1;
    chk("R1 b_oe", b_oe, 0); chk("R1 a_oe", a_oe, 0);
    chk("R1 b_out", b_out, 0); chk("R1 a_out", a_out, 0);
    step(); rst_n = 1; #1;
    chk("R1 ab bank zero", b_out, 0); chk("R1 ba bank zero", a_out, 0);
    chk("R5 b_oe on", b_oe, 1); chk("R5 a_oe on", a_oe, 1);
    ba_ce_n = 1; ba_oe_n = 1;

    // R2 R7: transparent sweep A to B
    step(); ab_le_n = 0;
    for (int v = 0; v < 256; v++) begin
      step(); a_in = v[W-1:0]; #1;
      chk("R2 R7 pass a->b", b_out, v);
      chk("R6 a side idle", a_out, 0);
    end

    // R8 R3: capture then hold
    for (int v = 3; v < 256; v += 37) begin
      step(); ab_le_n = 0; a_in = v[W-1:0];
      step(); ab_le_n = 1;
      for (int w = 0; w < 256; w += 17) begin
        step(); a_in = w[W-1:0]; #1;
        chk("R3 R8 hold", b_out, v);
      end
    end
    held = b_out;

    // R4: chip enable high blocks loading and driving
    step(); ab_ce_n = 1; ab_le_n = 0;
    for (int w = 0; w < 8; w++) begin
      step(); a_in = 8'hc3 ^ w[W-1:0]; #1;
      chk("R4 R5 off b_oe", b_oe, 0); chk("R5 off b_out", b_out, 0);
    end
    step(); ab_le_n = 1; ab_ce_n = 0; #1;
    chk("R4 kept value", b_out, held);

    // R5: every enable combination, source equal to held value
    step(); a_in = held;
    for (int c = 0; c < 8; c++) begin
      step(); ab_ce_n = c[0]; ab_le_n = c[1]; ab_oe_n = c[2]; #1;
      chk("R5 oe", b_oe, (!c[0] && !c[2]) ? 1 : 0);
      chk("R5 out", b_out, (!c[0] && !c[2]) ? held : 0);
    end
    step(); ab_ce_n = 0; ab_le_n = 1; ab_oe_n = 0;

    // R6: B to A transparent while A to B holds
    step(); ba_ce_n = 0; ba_oe_n = 0; ba_le_n = 0;
    for (int v = 0; v < 256; v++) begin
      step(); b_in = v[W-1:0]; a_in = ~v[W-1:0]; #1;
      chk("R6 R2 pass b->a", a_out, v);
      chk("R6 ab unaffected", b_out, held);
    end
    step(); b_in = 8'h96;
    step(); ba_le_n = 1;
    step(); b_in = 8'h00; #1;
    chk("R6 R8 ba hold", a_out, 8'h96);
    step(); ba_ce_n = 1; #1;
    chk("R6 R5 ba off", a_oe, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule